// File: doc/BRIEF.md
# Byte-Lane Synchronous SRAM with Selectable Read Latency

This block is a single-port synchronous memory whose words are split into independently writable byte lanes (four lanes of eight bits by default). Each clock cycle is decoded from active-low control inputs into a read, a write of some lanes, or nothing. A global write-all input forces every lane to be written. Otherwise a lane-write qualifier, together with one active-low select per lane, picks which lanes take the write data. A cycle that writes no lane is a read, and a read always returns the full word.

A latency select input picks the read timing. With the select low, read data comes straight from the array one cycle after the address is sampled. With it high, the data passes through an extra output register and arrives a cycle later. A standby input stops all activity: writes are dropped, no read is launched, the output is released and the stored words are kept. The output is a data bus plus an output-enable flag. Whenever the enable is low, the bus reads as zero.

Top module: `bytelane_sram`

## Requirements
- R1: When `wr_all_n` is low and `standby` is low, every lane of the word at `addr` is written from `wdata`, whatever `lane_wr_n` and `lane_sel_n` are.
- R2: When `wr_all_n` is high, `lane_wr_n` is low and `standby` is low, lane i (`wdata` bits i*8+7 down to i*8) is written exactly when `lane_sel_n[i]` is low. Any mix of lanes is allowed, and the other lanes keep their contents.
- R3: A cycle is a read when `standby` is low and no lane is written. That is the case when `wr_all_n` and `lane_wr_n` are both high, or when `wr_all_n` is high, `lane_wr_n` is low and all of `lane_sel_n` are high.
- R4: A read returns all lanes of the stored word, whatever the values of `lane_sel_n`.
- R5: With `pipe_sel` low, a read sampled at one clock edge raises `rdata_oe` and presents the word in the cycle that follows that edge.
- R6: With `pipe_sel` high, the read result appears one cycle later than in R5. It holds the word as the array stood when the read was sampled, even if the next cycle writes that address.
- R7: In any cycle in which a write is presented (and `standby` is low), `rdata_oe` is low, even if a read result is due in that cycle.
- R8: While `standby` is high, writes are ignored, no read is launched, `rdata_oe` is low and the stored contents are kept.
- R9: While `rst_n` is low, `rdata_oe` is low. No read that was in flight before reset is presented after reset.
- R10: Whenever `rdata_oe` is low, `rdata` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the read pipeline |
| addr | input | AW (6) | Word address for read or write |
| wdata | input | LANES*LANE_W (32) | Write data, lane i in bits i*LANE_W upward |
| wr_all_n | input | 1 | Active-low write of all lanes |
| lane_wr_n | input | 1 | Active-low qualifier enabling per-lane writes |
| lane_sel_n | input | LANES (4) | Active-low per-lane write selects |
| pipe_sel | input | 1 | 0: one-cycle read latency, 1: two-cycle read latency |
| standby | input | 1 | High suspends all reads and writes |
| rdata | output | LANES*LANE_W (32) | Read data, zero while released |
| rdata_oe | output | 1 | High while rdata carries a valid read word |

## Verification
The case to watch is a read result that falls due in the same cycle as a write or a standby request. The release of the bus must win, and the write must still land in the array. The bench provokes this by placing a write directly after a read in both latency modes, and a standby cycle directly after a read. In those cycles it expects `rdata_oe` low and a zero bus. Later reads show whether the write was stored (or, under standby, dropped), and whether the pipelined result already in flight kept the word from before the write.

// File: rtl/bls_pkg.sv
`timescale 1ns/1ps
package bls_pkg;

   typedef enum logic [1:0] {
      OP_NONE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } bls_op_e;

   function automatic logic is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/bls_wr_decode.sv
`timescale 1ns/1ps
module bls_wr_decode
   import bls_pkg::*;
#(
   parameter int unsigned LANES = 4
) (
   input  logic             wr_all_n,
   input  logic             lane_wr_n,
   input  logic [LANES-1:0] lane_sel_n,
   input  logic             standby,
   output logic [LANES-1:0] lane_we,
   output bls_op_e          op
);

   always_comb begin
      lane_we = '0;
      if (!standby) begin
         if (!wr_all_n) begin
            lane_we = '1;
         end else if (!lane_wr_n) begin
            lane_we = ~lane_sel_n;
         end
      end
   end

   always_comb begin
      if (standby) begin
         op = OP_NONE;
      end else if (|lane_we) begin
         op = OP_WRITE;
      end else begin
         op = OP_READ;
      end
   end

endmodule

// File: rtl/bls_lane_store.sv
`timescale 1ns/1ps
module bls_lane_store #(
   parameter int unsigned LANES  = 4,
   parameter int unsigned LANE_W = 8,
   parameter int unsigned DEPTH  = 64,
   localparam int unsigned AW    = $clog2(DEPTH),
   localparam int unsigned DW    = LANES * LANE_W
) (
   input  logic             clk,
   input  logic [LANES-1:0] lane_we,
   input  logic [AW-1:0]    waddr,
   input  logic [DW-1:0]    wdata,
   input  logic [AW-1:0]    raddr,
   output logic [DW-1:0]    rdata
);

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] bank [DEPTH];

      always_ff @(posedge clk) begin
         if (lane_we[g]) begin
            bank[waddr] <= wdata[g*LANE_W +: LANE_W];
         end
      end

      assign rdata[g*LANE_W +: LANE_W] = bank[raddr];
   end

endmodule

// File: rtl/bls_read_path.sv
`timescale 1ns/1ps
module bls_read_path #(
   parameter int unsigned DW = 32,
   parameter int unsigned AW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_issue,
   input  logic [AW-1:0] rd_addr,
   input  logic          pipe_sel,
   input  logic          hold_off,
   input  logic [DW-1:0] arr_q,
   output logic [AW-1:0] arr_addr,
   output logic [DW-1:0] dout,
   output logic          dout_oe
);

   logic          s1_vld;
   logic [AW-1:0] s1_addr;
   logic          s2_vld;
   logic [DW-1:0] s2_q;
   logic          sel_vld;
   logic [DW-1:0] sel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_vld  <= 1'b0;
         s1_addr <= '0;
         s2_vld  <= 1'b0;
         s2_q    <= '0;
      end else begin
         s1_vld  <= rd_issue;
         s1_addr <= rd_addr;
         s2_vld  <= s1_vld;
         s2_q    <= arr_q;
      end
   end

   assign arr_addr = s1_addr;

   always_comb begin
      if (pipe_sel) begin
         sel_vld = s2_vld;
         sel_q   = s2_q;
      end else begin
         sel_vld = s1_vld;
         sel_q   = arr_q;
      end
   end

   assign dout_oe = sel_vld & ~hold_off;
   assign dout    = dout_oe ? sel_q : '0;

endmodule

// File: rtl/bytelane_sram.sv
`timescale 1ns/1ps
module bytelane_sram
   import bls_pkg::*;
#(
   parameter int unsigned LANES  = 4,
   parameter int unsigned LANE_W = 8,
   parameter int unsigned DEPTH  = 64,
   localparam int unsigned AW    = $clog2(DEPTH),
   localparam int unsigned DW    = LANES * LANE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [AW-1:0]    addr,
   input  logic [DW-1:0]    wdata,
   input  logic             wr_all_n,
   input  logic             lane_wr_n,
   input  logic [LANES-1:0] lane_sel_n,
   input  logic             pipe_sel,
   input  logic             standby,
   output logic [DW-1:0]    rdata,
   output logic             rdata_oe
);

   if (LANES < 1) begin : g_bad_lanes
      $error("bytelane_sram: LANES must be at least 1");
   end
   if (LANE_W < 1) begin : g_bad_width
      $error("bytelane_sram: LANE_W must be at least 1");
   end
   if (DEPTH < 2 || !is_pow2(DEPTH)) begin : g_bad_depth
      $error("bytelane_sram: DEPTH must be a power of two, 2 or more");
   end

   logic [LANES-1:0] lane_we;
   bls_op_e          op;
   logic [AW-1:0]    arr_addr;
   logic [DW-1:0]    arr_q;

   bls_wr_decode #(
      .LANES(LANES)
   ) u_decode (
      .wr_all_n   (wr_all_n),
      .lane_wr_n  (lane_wr_n),
      .lane_sel_n (lane_sel_n),
      .standby    (standby),
      .lane_we    (lane_we),
      .op         (op)
   );

   bls_lane_store #(
      .LANES (LANES),
      .LANE_W(LANE_W),
      .DEPTH (DEPTH)
   ) u_store (
      .clk    (clk),
      .lane_we(lane_we),
      .waddr  (addr),
      .wdata  (wdata),
      .raddr  (arr_addr),
      .rdata  (arr_q)
   );

   bls_read_path #(
      .DW(DW),
      .AW(AW)
   ) u_rpath (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_issue (op == OP_READ),
      .rd_addr  (addr),
      .pipe_sel (pipe_sel),
      .hold_off (op != OP_READ),
      .arr_q    (arr_q),
      .arr_addr (arr_addr),
      .dout     (rdata),
      .dout_oe  (rdata_oe)
   );

endmodule

// File: rtl/bls_sram_chk.sv
`timescale 1ns/1ps
module bls_sram_chk #(
   parameter int unsigned LANES  = 4,
   parameter int unsigned LANE_W = 8
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    wr_all_n,
   input logic                    lane_wr_n,
   input logic [LANES-1:0]        lane_sel_n,
   input logic                    pipe_sel,
   input logic                    standby,
   input logic [LANES*LANE_W-1:0] rdata,
   input logic                    rdata_oe
);

   logic wr_pat;
   logic wr_now;
   logic rd_now;
   logic rd_d1;
   logic rd_d2;

   assign wr_pat = !wr_all_n || (!lane_wr_n && (lane_sel_n != '1));
   assign wr_now = !standby && wr_pat;
   assign rd_now = !standby && !wr_pat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_d1 <= 1'b0;
         rd_d2 <= 1'b0;
      end else begin
         rd_d1 <= rd_now;
         rd_d2 <= rd_d1;
      end
   end

   assert_flow_due_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!pipe_sel && rd_d1 && rd_now) |-> rdata_oe);

   assert_flow_none_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!pipe_sel && !rd_d1) |-> !rdata_oe);

   assert_pipe_due_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pipe_sel && rd_d2 && rd_now) |-> rdata_oe);

   assert_pipe_none_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pipe_sel && !rd_d2) |-> !rdata_oe);

   assert_write_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_now |-> !rdata_oe);

   assert_standby_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      standby |-> !rdata_oe);

   assert_zero_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !rdata_oe |-> (rdata == '0));

endmodule

bind bytelane_sram bls_sram_chk #(
   .LANES (LANES),
   .LANE_W(LANE_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_all_n  (wr_all_n),
   .lane_wr_n (lane_wr_n),
   .lane_sel_n(lane_sel_n),
   .pipe_sel  (pipe_sel),
   .standby   (standby),
   .rdata     (rdata),
   .rdata_oe  (rdata_oe)
);

// File: tb/bytelane_sram_tb.sv
`timescale 1ns/1ps
module bytelane_sram_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic        wr_all_n = 1'b1;
   logic        lane_wr_n = 1'b1;
   logic [3:0]  lane_sel_n = 4'hF;
   logic        pipe_sel = 1'b0;
   logic        standby = 1'b0;
   logic [31:0] rdata;
   logic        rdata_oe;

   int n_run  = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   bytelane_sram u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr      (addr),
      .wdata     (wdata),
      .wr_all_n  (wr_all_n),
      .lane_wr_n (lane_wr_n),
      .lane_sel_n(lane_sel_n),
      .pipe_sel  (pipe_sel),
      .standby   (standby),
      .rdata     (rdata),
      .rdata_oe  (rdata_oe)
   );

   // fields: wr_all_n, lane_wr_n, lane_sel_n, pipe_sel, standby, addr, wdata, exp_oe, exp_rdata
   localparam int NV = 18;
   localparam logic [78:0] VEC [NV] = '{
      {1'b0, 1'b1, 4'b1111, 1'b0, 1'b0, 6'd1, 32'h11223344, 1'b0, 32'h00000000}, // R1 write all
      {1'b1, 1'b0, 4'b1110, 1'b0, 1'b0, 6'd1, 32'hAABBCCDD, 1'b0, 32'h00000000}, // R2 lane 0
      {1'b1, 1'b0, 4'b0101, 1'b0, 1'b0, 6'd1, 32'h55667788, 1'b0, 32'h00000000}, // R2 lanes 1,3
      {1'b1, 1'b1, 4'b0000, 1'b0, 1'b0, 6'd1, 32'h00000000, 1'b0, 32'h00000000}, // R3 read
      {1'b1, 1'b0, 4'b1111, 1'b0, 1'b0, 6'd1, 32'h00000000, 1'b1, 32'h552277DD}, // R5 result
      {1'b0, 1'b1, 4'b1111, 1'b0, 1'b0, 6'd2, 32'hCAFEF00D, 1'b0, 32'h00000000}, // R7 write wins
      {1'b1, 1'b1, 4'b1010, 1'b0, 1'b0, 6'd2, 32'h00000000, 1'b0, 32'h00000000},
      {1'b0, 1'b1, 4'b1111, 1'b0, 1'b1, 6'd2, 32'h00000000, 1'b0, 32'h00000000}, // R8 standby
      {1'b1, 1'b1, 4'b1111, 1'b0, 1'b0, 6'd2, 32'h00000000, 1'b0, 32'h00000000},
      {1'b1, 1'b1, 4'b1111, 1'b1, 1'b0, 6'd1, 32'h00000000, 1'b0, 32'h00000000}, // R6 switch
      {1'b1, 1'b0, 4'b1111, 1'b1, 1'b0, 6'd2, 32'h00000000, 1'b1, 32'hCAFEF00D}, // R8 kept
      {1'b1, 1'b0, 4'b1011, 1'b1, 1'b0, 6'd2, 32'h00990000, 1'b0, 32'h00000000}, // R7 pipe
      {1'b1, 1'b1, 4'b1111, 1'b1, 1'b0, 6'd2, 32'h00000000, 1'b1, 32'hCAFEF00D}, // R6 old word
      {1'b1, 1'b1, 4'b1111, 1'b1, 1'b0, 6'd1, 32'h00000000, 1'b0, 32'h00000000},
      {1'b1, 1'b1, 4'b1111, 1'b1, 1'b0, 6'd2, 32'h00000000, 1'b1, 32'hCA99F00D}, // R2 lane 2
      {1'b1, 1'b1, 4'b1111, 1'b0, 1'b0, 6'd1, 32'h00000000, 1'b1, 32'hCA99F00D}, // R5 switch
      {1'b1, 1'b1, 4'b0000, 1'b0, 1'b0, 6'd1, 32'h00000000, 1'b1, 32'h552277DD},
      {1'b1, 1'b1, 4'b1111, 1'b0, 1'b0, 6'd1, 32'h00000000, 1'b1, 32'h552277DD}  // R4 full word
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic drive_rd(input logic [5:0] a, input logic p);
      wr_all_n   = 1'b1;
      lane_wr_n  = 1'b1;
      lane_sel_n = 4'hF;
      standby    = 1'b0;
      pipe_sel   = p;
      addr       = a;
      wdata      = '0;
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      // R9: reset state
      repeat (2) @(negedge clk);
      #1;
      chk("R9 oe in reset", {31'd0, rdata_oe}, 32'd0);
      chk("R10 bus in reset", rdata, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         logic [78:0] v;
         v = VEC[i];
         @(negedge clk);
         wr_all_n   = v[78];
         lane_wr_n  = v[77];
         lane_sel_n = v[76:73];
         pipe_sel   = v[72];
         standby    = v[71];
         addr       = v[70:65];
         wdata      = v[64:33];
         #1;
         chk($sformatf("R1-R8 vec %0d oe", i), {31'd0, rdata_oe}, {31'd0, v[32]});
         chk($sformatf("R10 vec %0d data", i), rdata, v[31:0]);
      end

      // R2 all four lanes through the qualifier, then R3/R4 read back
      @(negedge clk);
      wr_all_n = 1'b1; lane_wr_n = 1'b0; lane_sel_n = 4'b0000;
      pipe_sel = 1'b0; standby = 1'b0; addr = 6'd3; wdata = 32'h01020304;
      @(negedge clk);
      drive_rd(6'd3, 1'b0);
      #1;
      chk("R7 oe after write", {31'd0, rdata_oe}, 32'd0);
      @(negedge clk);
      drive_rd(6'd1, 1'b0);
      #1;
      chk("R2 four lanes via qualifier", rdata, 32'h01020304);
      chk("R4 oe on read", {31'd0, rdata_oe}, 32'd1);

      // R9: reset with a read in flight
      @(negedge clk);
      drive_rd(6'd1, 1'b0);
      #1;
      chk("R5 before reset", rdata, 32'h552277DD);
      rst_n = 1'b0;
      #1;
      chk("R9 oe dropped by reset", {31'd0, rdata_oe}, 32'd0);
      chk("R9 bus zero in reset", rdata, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      drive_rd(6'd1, 1'b0);
      #1;
      chk("R9 no stale read after reset", {31'd0, rdata_oe}, 32'd0);
      @(negedge clk);
      drive_rd(6'd1, 1'b0);
      #1;
      chk("R5 first read after reset", rdata, 32'h552277DD);

      // R8: standby directly after a read, then contents kept
      @(negedge clk);
      standby = 1'b1; wr_all_n = 1'b0; wdata = 32'hFFFFFFFF; addr = 6'd3;
      #1;
      chk("R8 standby releases bus", {31'd0, rdata_oe}, 32'd0);
      @(negedge clk);
      drive_rd(6'd3, 1'b0);
      @(negedge clk);
      drive_rd(6'd3, 1'b0);
      #1;
      chk("R8 contents kept", rdata, 32'h01020304);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule